// File: doc/BRIEF.md
# Multi-Issue Field-Operation Dispatcher

This block sits between a host and a bank of fixed-latency field-arithmetic units. The host writes 32-bit operation words one per cycle. They wait in an eight-entry pending buffer, and the block tells the host when that buffer has no room. Each cycle the dispatcher looks at the four oldest pending words. It sends every one that is free of hazards, up to the number of idle units, to its own unit in the same cycle. A younger word may go before an older one that is stalled, but only when the two share no register.

Operands are read from a sixteen-entry register file when a word is issued. The unit holds the result for a fixed number of cycles and then requests a write-back. The register file takes one write per cycle. Results that are ready together are written oldest first. A per-register pending bit marks every destination that is still in flight. The arithmetic is a simple bitwise stand-in that exercises the three source operands. A combinational read port exposes the register file.

Top module: `dispatcher`

## Requirements
- R1: Word fields: bits [27:24] destination, [23:20] source A, [19:16] source B, [15:12] source C. Bits [29:28] select the operation: 0 load immediate (destination gets bits [23:0] zero-extended, no sources read), 1 gives (A&B)^C, 2 gives A^B^C, 3 gives A&(B^C). Bits [31:30] and [11:0] are ignored.
- R2: The buffer holds 8 words. A word is taken when instr_valid_i is high and buf_full_o is low. buf_full_o is high exactly while 8 words are held, and a word offered while it is high is dropped with no effect on any register.
- R3: With no hazard and a free unit, a word captured at clock edge N is issued at edge N+1, and its result is visible on the read port after edge N+9.
- R4: A word is not issued while any register it reads, or its destination, has a write in flight. It issues on the edge after that write lands and uses the written value.
- R5: A word among the four oldest that has no hazard is issued ahead of an older stalled word.
- R6: Up to four words issue in the same cycle, one per unit. A unit takes no new word until its result has been written.
- R7: At most one register is written per cycle. Results ready in the same cycle are written in issue order, and words issued together count as older in buffer order.
- R8: A word never passes an older pending word with which it shares a register (read-after-write, write-after-read or write-after-write), so the final register contents equal those of in-order execution.
- R9: After reset every register reads zero, the buffer is empty and buf_full_o is low.
- R10: rd_data_o shows the register selected by rd_addr_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Host offers a word this cycle |
| instr_i | input | 32 | Operation word |
| buf_full_o | output | 1 | Pending buffer has no room |
| rd_addr_i | input | 4 | Register select for the read port |
| rd_data_o | output | DW (32) | Selected register contents |

## Verification
The hardest case to reach from the ports is several results finishing in the same cycle, because the host can only push one word per cycle. The bench gets there by loading a register and then filling the buffer with words that all read it. They all stall until the load lands, and four of them then issue together. The bench observes the staggered writes one cycle apart on the read port, and at the same time a push into the full buffer is dropped. Hidden reordering errors are revealed by a write-after-read case whose result differs if a younger load slips past, and by a pseudo-random stream compared against a sequential model.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned IW   = 32;
  localparam int unsigned NREG = 16;

  typedef logic [3:0] ridx_t;
  typedef enum logic [1:0] {OP_LDI = 2'd0, OP_ANDX = 2'd1, OP_XOR3 = 2'd2, OP_AXOR = 2'd3} op_e;

  function automatic op_e   op_of (input logic [IW-1:0] w); return op_e'(w[29:28]); endfunction
  function automatic ridx_t dst_of(input logic [IW-1:0] w); return w[27:24]; endfunction
  function automatic ridx_t sa_of (input logic [IW-1:0] w); return w[23:20]; endfunction
  function automatic ridx_t sb_of (input logic [IW-1:0] w); return w[19:16]; endfunction
  function automatic ridx_t sc_of (input logic [IW-1:0] w); return w[15:12]; endfunction
  function automatic logic [23:0] imm_of(input logic [IW-1:0] w); return w[23:0]; endfunction

  function automatic logic uses_src(input logic [IW-1:0] w);
    return w[29:28] != 2'd0;
  endfunction

  function automatic logic reads(input logic [IW-1:0] w, input ridx_t r);
    return uses_src(w) && (sa_of(w) == r || sb_of(w) == r || sc_of(w) == r);
  endfunction
endpackage

// File: rtl/disp_queue.sv
module disp_queue #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIN   = 4,
  parameter int unsigned IW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [IW-1:0]           data_i,
  input  logic [WIN-1:0]          issue_i,
  output logic [WIN-1:0][IW-1:0]  win_o,
  output logic [WIN-1:0]          win_vld_o,
  output logic                    full_o,
  output logic [CW-1:0]           cnt_o
);
  logic [DEPTH-1:0][IW-1:0] mem_q, mem_d;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [DEPTH-1:0]         iss;

  assign full_o = (cnt_q == CW'(DEPTH));
  assign cnt_o  = cnt_q;

  // compact survivors toward the head, then append
  always_comb begin
    iss = '0;
    iss[WIN-1:0] = issue_i;
    mem_d = mem_q;
    cnt_d = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q > CW'(i) && !iss[i]) begin
        mem_d[cnt_d[AW-1:0]] = mem_q[i];
        cnt_d = cnt_d + 1'b1;
      end
    end
    if (push_i && !full_o) begin
      mem_d[cnt_d[AW-1:0]] = data_i;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < WIN; i++) begin : g_win
    assign win_o[i]     = mem_q[i];
    assign win_vld_o[i] = cnt_q > CW'(i);
  end
endmodule

// File: rtl/disp_select.sv
module disp_select
  import disp_pkg::*;
#(
  parameter int unsigned WIN = 4,
  parameter int unsigned NU  = 4
) (
  input  logic [WIN-1:0][IW-1:0] win_i,
  input  logic [WIN-1:0]         win_vld_i,
  input  logic [NREG-1:0]        sb_i,
  input  logic [NU-1:0]          busy_i,
  output logic [WIN-1:0]         issue_o,
  output logic [NU-1:0]          go_o,
  output logic [NU-1:0][IW-1:0]  slot_o
);
  logic [WIN-1:0] ok;
  logic [NU-1:0]  avail;
  logic           placed;

  always_comb begin
    for (int i = 0; i < WIN; i++) begin
      ok[i] = win_vld_i[i] && !sb_i[dst_of(win_i[i])];
      if (uses_src(win_i[i]) &&
          (sb_i[sa_of(win_i[i])] || sb_i[sb_of(win_i[i])] || sb_i[sc_of(win_i[i])]))
        ok[i] = 1'b0;
      // any register shared with an older pending word blocks
      for (int j = 0; j < i; j++) begin
        if (win_vld_i[j] &&
            (reads(win_i[i], dst_of(win_i[j])) ||
             reads(win_i[j], dst_of(win_i[i])) ||
             dst_of(win_i[i]) == dst_of(win_i[j])))
          ok[i] = 1'b0;
      end
    end
  end

  always_comb begin
    avail   = ~busy_i;
    issue_o = '0;
    go_o    = '0;
    slot_o  = '0;
    placed  = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      placed = 1'b0;
      if (ok[i]) begin
        for (int u = 0; u < NU; u++) begin
          if (!placed && avail[u]) begin
            avail[u]  = 1'b0;
            go_o[u]   = 1'b1;
            slot_o[u] = win_i[i];
            placed    = 1'b1;
          end
        end
      end
      issue_o[i] = placed;
    end
  end
endmodule

// File: rtl/disp_unit.sv
module disp_unit
  import disp_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned LAT = 8,
  localparam int unsigned CW = $clog2(LAT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  op_e           op_i,
  input  ridx_t         dst_i,
  input  logic [23:0]   imm_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] opc_i,
  input  logic          grant_i,
  output logic          busy_o,
  output logic          done_o,
  output ridx_t         dst_o,
  output logic [DW-1:0] res_o
);
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] res_d;

  always_comb begin
    res_d = '0;
    case (op_i)
      OP_LDI:  res_d = DW'(imm_i);
      OP_ANDX: res_d = (opa_i & opb_i) ^ opc_i;
      OP_XOR3: res_d = opa_i ^ opb_i ^ opc_i;
      OP_AXOR: res_d = opa_i & (opb_i ^ opc_i);
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
      dst_o  <= '0;
      res_o  <= '0;
    end else if (go_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(LAT - 1);
      dst_o  <= dst_i;
      res_o  <= res_d;
    end else if (busy_o) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (grant_i) busy_o <= 1'b0;
    end
  end

  assign done_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/disp_wb_arb.sv
module disp_wb_arb #(
  parameter int unsigned NU = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NU-1:0] go_i,
  input  logic [NU-1:0] busy_i,
  input  logic [NU-1:0] done_i,
  output logic [NU-1:0] grant_o
);
  // age_q[a][b]: unit a holds an older word than unit b
  logic [NU-1:0][NU-1:0] age_q, age_d;

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      grant_o[u] = done_i[u];
      for (int v = 0; v < NU; v++)
        if (done_i[v] && age_q[v][u]) grant_o[u] = 1'b0;
    end
  end

  always_comb begin
    age_d = age_q;
    for (int v = 0; v < NU; v++) begin
      if (go_i[v]) begin
        for (int u = 0; u < NU; u++) begin
          if (u != v && ((busy_i[u] && !grant_o[u]) || (go_i[u] && u < v))) begin
            age_d[u][v] = 1'b1;
            age_d[v][u] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= age_d;
  end
endmodule

// File: rtl/dispatcher.sv
module dispatcher
  import disp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIN   = 4,
  parameter int unsigned NU    = 4,
  parameter int unsigned LAT   = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          instr_valid_i,
  input  logic [31:0]   instr_i,
  output logic          buf_full_o,
  input  logic [3:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [WIN-1:0][IW-1:0] win;
  logic [WIN-1:0]         win_vld, issue;
  logic [CW-1:0]          q_cnt;
  logic [NU-1:0]          go, busy, done, grant;
  logic [NU-1:0][IW-1:0]  slot;
  logic [NU-1:0][3:0]     go_dst, wb_dst;
  logic [NU-1:0][DW-1:0]  wb_res;
  logic [NREG-1:0]        sb_q, sb_d;
  logic [NREG-1:0][DW-1:0] rf_q;

  disp_queue #(.DEPTH(DEPTH), .WIN(WIN), .IW(IW)) u_queue (
    .clk_i, .rst_ni, .push_i(instr_valid_i), .data_i(instr_i), .issue_i(issue),
    .win_o(win), .win_vld_o(win_vld), .full_o(buf_full_o), .cnt_o(q_cnt)
  );

  disp_select #(.WIN(WIN), .NU(NU)) u_sel (
    .win_i(win), .win_vld_i(win_vld), .sb_i(sb_q), .busy_i(busy),
    .issue_o(issue), .go_o(go), .slot_o(slot)
  );

  for (genvar u = 0; u < NU; u++) begin : g_unit
    assign go_dst[u] = dst_of(slot[u]);
    disp_unit #(.DW(DW), .LAT(LAT)) u_unit (
      .clk_i, .rst_ni, .go_i(go[u]), .op_i(op_of(slot[u])), .dst_i(dst_of(slot[u])),
      .imm_i(imm_of(slot[u])), .opa_i(rf_q[sa_of(slot[u])]), .opb_i(rf_q[sb_of(slot[u])]),
      .opc_i(rf_q[sc_of(slot[u])]), .grant_i(grant[u]), .busy_o(busy[u]),
      .done_o(done[u]), .dst_o(wb_dst[u]), .res_o(wb_res[u])
    );
  end

  disp_wb_arb #(.NU(NU)) u_arb (
    .clk_i, .rst_ni, .go_i(go), .busy_i(busy), .done_i(done), .grant_o(grant)
  );

  always_comb begin
    sb_d = sb_q;
    for (int u = 0; u < NU; u++) if (grant[u]) sb_d[wb_dst[u]] = 1'b0;
    for (int u = 0; u < NU; u++) if (go[u])    sb_d[go_dst[u]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sb_q <= '0;
      rf_q <= '0;
    end else begin
      sb_q <= sb_d;
      for (int u = 0; u < NU; u++) if (grant[u]) rf_q[wb_dst[u]] <= wb_res[u];
    end
  end

  assign rd_data_o = rf_q[rd_addr_i];
endmodule

// File: rtl/disp_chk.sv
module disp_chk #(
  parameter int unsigned NU = 4,
  parameter int unsigned CW = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               instr_valid_i,
  input logic               buf_full_o,
  input logic [CW-1:0]      q_cnt,
  input logic [NU-1:0]      go,
  input logic [NU-1:0]      busy,
  input logic [NU-1:0]      grant,
  input logic [NU-1:0][3:0] go_dst,
  input logic [15:0]        sb_q
);
  p_one_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(grant));

  p_go_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) (go & busy) == '0);

  p_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_o && instr_valid_i |=> q_cnt <= $past(q_cnt));

  for (genvar u = 0; u < NU; u++) begin : g_u
    p_go_sb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      go[u] |-> !sb_q[go_dst[u]]);
    p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy[u] && !grant[u] |=> busy[u]);
  end
endmodule

bind dispatcher disp_chk #(.NU(NU), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i), .buf_full_o(buf_full_o),
  .q_cnt(q_cnt), .go(go), .busy(busy), .grant(grant), .go_dst(go_dst), .sb_q(sb_q)
);

// File: tb/tb_dispatcher.sv
module tb_dispatcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        buf_full;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [16];

  always #4 clk = ~clk;

  dispatcher dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .buf_full_o(buf_full), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [31:0] ldi(input int d, input logic [23:0] imm);
    return {4'h0, d[3:0], imm};
  endfunction
  function automatic logic [31:0] alu(input int op, input int d, input int a, input int b, input int c);
    return {2'b11, op[1:0], d[3:0], a[3:0], b[3:0], c[3:0], 12'hA5C};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input int r, input logic [31:0] exp);
    rd_addr = r[3:0];
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a negedge; word captured at next posedge; returns at following negedge
  task automatic push(input logic [31:0] w);
    instr_valid = 1'b1;
    instr = w;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R9 full after reset", {31'b0, buf_full}, 32'd0);
    for (int r = 0; r < 16; r++) chk_reg("R9 R10 reg after reset", r, 32'd0);
  endtask

  task automatic t_latency();
    do_reset();
    push(ldi(1, 24'h000123));
    repeat (8) @(negedge clk);
    chk_reg("R3 before edge N+9", 1, 32'd0);
    @(negedge clk);
    chk_reg("R3 R1 at edge N+9", 1, 32'h123);
  endtask

  task automatic t_ooo();
    do_reset();
    push(ldi(2, 24'h000ABC));
    push(alu(2, 3, 2, 0, 0));
    push(ldi(4, 24'h000055));
    repeat (9) @(negedge clk);
    chk_reg("R5 younger done", 4, 32'h55);
    chk_reg("R4 R5 stalled not done", 3, 32'd0);
    repeat (6) @(negedge clk);
    chk_reg("R4 one before", 3, 32'd0);
    @(negedge clk);
    chk_reg("R4 R1 reads new value", 3, 32'hABC);
  endtask

  task automatic t_war();
    do_reset();
    push(ldi(2, 24'h000007));
    push(alu(1, 7, 2, 6, 0));
    push(ldi(6, 24'h0000FF));
    repeat (40) @(negedge clk);
    chk_reg("R8 older read not overtaken", 7, 32'd0);
    chk_reg("R8 younger write", 6, 32'hFF);
    chk_reg("R1 andx", 2, 32'h7);
  endtask

  task automatic t_full();
    do_reset();
    push(ldi(0, 24'h003C5A));
    for (int k = 1; k <= 8; k++) begin
      if (k == 8) check("R2 not full at 7", {31'b0, buf_full}, 32'd0);
      push(alu(3, k, 0, 0, 13));
    end
    check("R2 full at 8", {31'b0, buf_full}, 32'd1);
    push(ldi(14, 24'h000777));
    check("R2 full held", {31'b0, buf_full}, 32'd1);
    @(negedge clk);
    check("R6 four issued, room again", {31'b0, buf_full}, 32'd0);
    repeat (8) @(negedge clk);
    chk_reg("R7 first write", 1, 32'h3C5A);
    chk_reg("R7 second not yet", 2, 32'd0);
    @(negedge clk);
    chk_reg("R7 second write", 2, 32'h3C5A);
    chk_reg("R7 third not yet", 3, 32'd0);
    @(negedge clk);
    chk_reg("R7 third write", 3, 32'h3C5A);
    chk_reg("R7 fourth not yet", 4, 32'd0);
    @(negedge clk);
    chk_reg("R7 fourth write", 4, 32'h3C5A);
    repeat (5) @(negedge clk);
    chk_reg("R6 unit busy until written", 5, 32'd0);
    @(negedge clk);
    chk_reg("R6 reused unit result", 5, 32'h3C5A);
    repeat (30) @(negedge clk);
    for (int k = 6; k <= 8; k++) chk_reg("R6 remaining", k, 32'h3C5A);
    chk_reg("R2 dropped word no effect", 14, 32'd0);
  endtask

  task automatic t_stream();
    logic [31:0] x;
    logic [31:0] w;
    int op, d, a, b, c;
    do_reset();
    for (int r = 0; r < 16; r++) model[r] = '0;
    x = 32'h1D872B41;
    for (int n = 0; n < 60; n++) begin
      x = {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
      op = int'(x[1:0]); d = int'(x[4:2]); a = int'(x[7:5]); b = int'(x[10:8]); c = int'(x[13:11]);
      if (op == 0) begin
        w = ldi(d, x[31:8]);
        model[d] = {8'b0, x[31:8]};
      end else begin
        w = alu(op, d, a, b, c);
        case (op)
          1: model[d] = (model[a] & model[b]) ^ model[c];
          2: model[d] = model[a] ^ model[b] ^ model[c];
          default: model[d] = model[a] & (model[b] ^ model[c]);
        endcase
      end
      while (buf_full) @(negedge clk);
      push(w);
    end
    repeat (600) @(negedge clk);
    for (int r = 0; r < 16; r++) chk_reg("R8 R1 stream vs in-order model", r, model[r]);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_ooo();
    t_war();
    t_full();
    t_stream();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule